// File: doc/BRIEF.md
# Run-Length Sample Packer

This block sits between the read-back port of a logic-capture memory and a byte-wide serial transmitter. Each 32-bit sample arrives on a valid/ready input and leaves as bytes on a valid/ready output. The sample is split into four 8-bit channel groups, and only the groups that are switched on are sent. A narrower capture therefore costs fewer bytes on the link.

With run-length mode on, consecutive identical samples are folded. The block sends the sample once, then a count word whose most significant transmitted bit is set. The count tells the receiver how many additional times the sample occurred. Because of this, that top bit is always cleared in data words. The block forwards samples in the order it receives them, and the memory side supplies them newest first. A flag marking the final sample flushes any run still being counted.

The group-disable bits and the mode bit must stay constant while a stream is in progress.

Top module: `rl_sample_packer`

## Requirements
- R1: After reset, `m_valid` is 0 and `s_ready` is 1.
- R2: With run-length mode off, each accepted sample produces one byte per enabled group. Setting `grp_off[i]` to 1 disables bits [8i+7:8i]. Bytes go out lowest enabled group first, with disabled groups skipped, and samples are emitted in arrival order.
- R3: With all four groups disabled, samples are still accepted and no byte is produced.
- R4: With run-length mode on, let n be the number of enabled groups. In every data word, bit 8n-1 of the packed word (the top bit of the last byte sent) is forced to 0. With run-length mode off, that bit passes through unchanged.
- R5: With run-length mode on, a run of L identical samples with L > 1 is sent as the packed sample followed by a count word. The count word is L-1 with bit 8n-1 set, and it uses the same byte order as data. A run of length 1 is sent as the sample alone.
- R6: Samples are compared only on transmitted bits. Samples that differ only in disabled groups, or only in the forced bit, belong to the same run.
- R7: The count saturates at 2^(8n-1)-1. The next identical sample after that starts a new run.
- R8: In run-length mode, a run is emitted only when a different sample arrives, when it saturates, or when a sample arrives with `s_last` set. Until then no byte leaves the block. A sample with `s_last` joins or starts a run, and all pending runs are then sent.
- R9: While `m_ready` is 0, `m_valid` stays 1 and `m_data` stays stable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_valid | input | 1 | Sample valid |
| s_ready | output | 1 | Sample accepted when high with `s_valid` |
| s_data | input | 32 | Sample word |
| s_last | input | 1 | Final sample of the stream; flushes pending runs |
| grp_off | input | 4 | Per-group disable, bit i covers sample bits [8i+7:8i] |
| rle_en | input | 1 | Run-length compression on |
| m_valid | output | 1 | Byte valid |
| m_ready | input | 1 | Byte taken when high with `m_valid` |
| m_data | output | 8 | Output byte |

## Verification
The hardest situation to reach is count saturation. With all four groups enabled, the count limit is 2^31-1 and no stream of practical length can reach it. The stimulus therefore enables a single group, which lowers the limit to 127, and then feeds 130 identical samples. This crosses the limit and leaves a short second run, whose count word is checked as well. Folding across disabled groups and across the forced bit is reached by feeding samples that differ only in those bits.

// File: rtl/rlp_pkg.sv
package rlp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DATA = 2'd1,
    ST_CNT  = 2'd2
  } rlp_state_e;
endpackage

// File: rtl/rlp_compact.sv
module rlp_compact #(
  parameter int GROUPS = 4,
  parameter int GW     = 8
) (
  input  logic [GROUPS*GW-1:0]          raw,
  input  logic [GROUPS-1:0]             grp_off,
  input  logic                          rle_en,
  output logic [GROUPS*GW-1:0]          word,
  output logic [$clog2(GROUPS+1)-1:0]   nbytes,
  output logic [GROUPS*GW-1:0]          flag,
  output logic [GROUPS*GW-1:0]          cmax
);
  localparam int DW = GROUPS*GW;
  localparam int NW = $clog2(GROUPS+1);

  logic [DW-1:0] packed_w;
  logic [NW-1:0] n_c;

  // squeeze enabled groups down to the low end, lowest group first
  always_comb begin
    packed_w = '0;
    n_c      = '0;
    for (int g = 0; g < GROUPS; g++) begin
      if (!grp_off[g]) begin
        packed_w[n_c*GW +: GW] = raw[g*GW +: GW];
        n_c = n_c + NW'(1);
      end
    end
  end

  always_comb begin
    if (n_c == '0) flag = '0;
    else           flag = DW'(1) << (n_c*GW - 1);
  end

  assign nbytes = n_c;
  assign cmax   = flag - DW'(1);
  assign word   = rle_en ? (packed_w & ~flag) : packed_w;
endmodule

// File: rtl/rlp_serial.sv
module rlp_serial #(
  parameter int GROUPS = 4,
  parameter int GW     = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        ld,
  input  logic [GROUPS*GW-1:0]        ld_word,
  input  logic [$clog2(GROUPS+1)-1:0] nbytes,
  output logic                        m_valid,
  input  logic                        m_ready,
  output logic [GW-1:0]               m_data,
  output logic                        fin
);
  localparam int DW = GROUPS*GW;
  localparam int NW = $clog2(GROUPS+1);

  logic          act_q, act_d;
  logic [NW-1:0] idx_q, idx_d;
  logic [DW-1:0] word_q;
  logic          last_byte;

  assign last_byte = (idx_q + NW'(1)) == nbytes;
  assign fin       = act_q & m_ready & last_byte;
  assign m_valid   = act_q;
  assign m_data    = word_q[idx_q*GW +: GW];

  always_comb begin
    act_d = act_q;
    idx_d = idx_q;
    if (act_q && m_ready) begin
      if (last_byte) act_d = 1'b0;
      else           idx_d = idx_q + NW'(1);
    end
    if (ld) begin
      act_d = 1'b1;
      idx_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      idx_q <= '0;
    end else begin
      act_q <= act_d;
      idx_q <= idx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  word_q <= '0;
    else if (ld) word_q <= ld_word;
  end

  AST_HOLD_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data))); // R9
  AST_LOAD_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    ld |-> (!act_q || fin)); // R2
endmodule

// File: rtl/rl_sample_packer.sv
module rl_sample_packer #(
  parameter int GROUPS = 4,
  parameter int GW     = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 s_valid,
  output logic                 s_ready,
  input  logic [GROUPS*GW-1:0] s_data,
  input  logic                 s_last,
  input  logic [GROUPS-1:0]    grp_off,
  input  logic                 rle_en,
  output logic                 m_valid,
  input  logic                 m_ready,
  output logic [GW-1:0]        m_data
);
  import rlp_pkg::*;
  localparam int DW = GROUPS*GW;
  localparam int NW = $clog2(GROUPS+1);

  // reset: asserted asynchronously, released on the clock
  logic rst_s1, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_q  <= rst_s1;
    end
  end

  logic [DW-1:0] cw, flag, cmax;
  logic [NW-1:0] nbytes;

  rlp_compact #(.GROUPS(GROUPS), .GW(GW)) u_cmp (
    .raw(s_data), .grp_off(grp_off), .rle_en(rle_en),
    .word(cw), .nbytes(nbytes), .flag(flag), .cmax(cmax)
  );

  rlp_state_e    st_q, st_d;
  logic [DW-1:0] held_q, held_d, nxt_q, nxt_d, cnt_q, cnt_d;
  logic          have_q, have_d, swap_q, swap_d, end_q, end_d;
  logic          ld, done, fin, fl;
  logic [DW-1:0] ldw;

  assign s_ready = (st_q == ST_IDLE);
  assign fl      = s_last | ~rle_en;

  always_comb begin
    st_d = st_q;  held_d = held_q; nxt_d = nxt_q; cnt_d = cnt_q;
    have_d = have_q; swap_d = swap_q; end_d = end_q;
    ld = 1'b0; ldw = '0; done = 1'b0;
    unique case (st_q)
      ST_IDLE: if (s_valid) begin
        if (nbytes == '0) begin
          have_d = 1'b0;
        end else if (!have_q) begin
          held_d = cw; cnt_d = '0; have_d = 1'b1;
          if (fl) begin ld = 1'b1; ldw = cw; st_d = ST_DATA; end_d = 1'b1; end
        end else if (cw == held_q && cnt_q < cmax) begin
          cnt_d = cnt_q + DW'(1);
          if (fl) begin ld = 1'b1; ldw = held_q; st_d = ST_DATA; end_d = 1'b1; end
        end else begin
          nxt_d = cw; swap_d = 1'b1; end_d = fl;
          ld = 1'b1; ldw = held_q; st_d = ST_DATA;
        end
      end
      ST_DATA: if (fin) begin
        if (cnt_q != '0) begin ld = 1'b1; ldw = cnt_q | flag; st_d = ST_CNT; end
        else done = 1'b1;
      end
      ST_CNT: if (fin) done = 1'b1;
      default: st_d = ST_IDLE;
    endcase
    if (done) begin
      if (swap_q) begin
        held_d = nxt_q; cnt_d = '0; swap_d = 1'b0; have_d = 1'b1;
        if (end_q) begin ld = 1'b1; ldw = nxt_q; st_d = ST_DATA; end
        else st_d = ST_IDLE;
      end else begin
        have_d = 1'b0; end_d = 1'b0; st_d = ST_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      st_q <= ST_IDLE; held_q <= '0; nxt_q <= '0; cnt_q <= '0;
      have_q <= 1'b0; swap_q <= 1'b0; end_q <= 1'b0;
    end else begin
      st_q <= st_d; held_q <= held_d; nxt_q <= nxt_d; cnt_q <= cnt_d;
      have_q <= have_d; swap_q <= swap_d; end_q <= end_d;
    end
  end

  rlp_serial #(.GROUPS(GROUPS), .GW(GW)) u_ser (
    .clk(clk), .rst_n(rst_q), .ld(ld), .ld_word(ldw), .nbytes(nbytes),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .fin(fin)
  );

  AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_q)
    s_ready |-> !m_valid); // R2
  AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_q)
    have_q |-> (cnt_q <= cmax)); // R7
  AST_DATA_TOP_CLEAR: assert property (@(posedge clk) disable iff (!rst_q)
    (ld && st_d == ST_DATA && rle_en) |-> ((ldw & flag) == '0)); // R4
  AST_EMPTY_SILENT: assert property (@(posedge clk) disable iff (!rst_q)
    (nbytes == '0) |-> !m_valid); // R3
endmodule

// File: tb/tb_rl_sample_packer.sv
`timescale 1ns/1ps
module tb_rl_sample_packer;
  logic        clk = 1'b0;
  logic        rst_n, s_valid, s_ready, s_last, rle_en, m_valid, m_ready;
  logic [31:0] s_data;
  logic [3:0]  grp_off;
  logic [7:0]  m_data;
  int checks = 0, errors = 0;
  logic [7:0] cap [512];
  int capn = 0;

  always #2 clk = ~clk;

  rl_sample_packer dut (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .s_last(s_last), .grp_off(grp_off), .rle_en(rle_en),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data)
  );

  always @(negedge clk) if (m_valid && m_ready) begin
    cap[capn % 512] <= m_data;
    capn <= capn + 1;
  end

  // {grp_off, sample, byte count, expected bytes (first byte lowest)}
  localparam logic [70:0] VEC [6] = '{
    {4'b0000, 32'h44332211, 3'd4, 32'h44332211},
    {4'b0101, 32'hDDCCBBAA, 3'd2, 32'h0000DDBB},
    {4'b1110, 32'h000000F5, 3'd1, 32'h000000F5},
    {4'b0111, 32'h9A000000, 3'd1, 32'h0000009A},
    {4'b0000, 32'h80000000, 3'd4, 32'h80000000},
    {4'b1001, 32'h00CDAB00, 3'd2, 32'h0000CDAB}
  };

  task automatic chk(input string tag, input bit ok, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] d, input logic last);
    s_data = d; s_last = last; s_valid = 1'b1;
    do @(negedge clk); while (!s_ready);
    @(posedge clk); #1;
    s_valid = 1'b0; s_last = 1'b0;
  endtask

  task automatic drain();
    repeat (30) @(posedge clk);
    #1;
  endtask

  // compares {count, bytes} captured since base
  task automatic chk_bytes(input string tag, input int base, input int n, input logic [55:0] exp);
    logic [55:0] v = '0;
    int got;
    drain();
    got = capn - base;
    for (int i = 0; i < got && i < 7; i++) v[i*8 +: 8] = cap[(base + i) % 512];
    chk(tag, (got == n) && (v == exp), {8'(got), v}, {8'(n), exp});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int base;
    rst_n = 1'b0; s_valid = 1'b0; s_last = 1'b0; s_data = '0;
    grp_off = '0; rle_en = 1'b0; m_ready = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 m_valid", m_valid == 1'b0, 64'(m_valid), 64'd0);
    chk("R1 s_ready", s_ready == 1'b1, 64'(s_ready), 64'd1);

    // R2 / R4 contrast: table walk, run-length mode off
    for (int i = 0; i < 6; i++) begin
      grp_off = VEC[i][70:67];
      base = capn;
      send(VEC[i][66:35], 1'b0);
      chk_bytes($sformatf("R2 vec%0d", i), base, int'(VEC[i][34:32]), {24'b0, VEC[i][31:0]});
    end

    // R3: all groups off
    grp_off = 4'b1111; base = capn;
    send(32'h12345678, 1'b0);
    chk_bytes("R3 no bytes", base, 0, 56'h0);

    rle_en = 1'b1;
    // R4: forced top bit
    grp_off = 4'b0000; base = capn;
    send(32'hFFFFFFFF, 1'b1);
    chk_bytes("R4 four groups", base, 4, 56'h7FFFFFFF);
    grp_off = 4'b1100; base = capn;
    send(32'h0000FFFF, 1'b1);
    chk_bytes("R4 two groups", base, 2, 56'h7FFF);

    // R5: run of 3 then a single; then two singles
    grp_off = 4'b1110; base = capn;
    send(32'h05, 1'b0); send(32'h05, 1'b0); send(32'h05, 1'b0); send(32'h09, 1'b1);
    chk_bytes("R5 run three", base, 3, 56'h098205);
    base = capn;
    send(32'h07, 1'b0); send(32'h08, 1'b1);
    chk_bytes("R5 singles", base, 2, 56'h0807);

    // R6: differences only in disabled groups or the forced bit
    base = capn;
    send(32'h00000011, 1'b0); send(32'hAB000011, 1'b0); send(32'h00000091, 1'b1);
    chk_bytes("R6 merge", base, 2, 56'h8211);

    // R7: saturation with one group: limit 127
    base = capn;
    for (int i = 0; i < 130; i++) send(32'h3C, i == 129);
    chk_bytes("R7 saturate", base, 4, 56'h813CFF3C);

    // R8: held run produces nothing until the last flag
    base = capn;
    send(32'h05, 1'b0); send(32'h05, 1'b0);
    drain();
    chk("R8 held silent", capn == base, 64'(capn - base), 64'd0);
    send(32'h05, 1'b1);
    chk_bytes("R8 flush", base, 2, 56'h8205);
    grp_off = 4'b1100; base = capn;
    send(32'h1234, 1'b0); send(32'h1234, 1'b0); send(32'h1234, 1'b1);
    chk_bytes("R8 two-group count", base, 4, 56'h80021234);

    // R9: backpressure
    rle_en = 1'b0; grp_off = 4'b0000; m_ready = 1'b0; base = capn;
    send(32'h44332211, 1'b0);
    repeat (2) @(negedge clk);
    chk("R9 valid held", m_valid && m_data == 8'h11, {55'b0, m_valid, m_data}, {55'b0, 1'b1, 8'h11});
    repeat (5) @(negedge clk);
    chk("R9 stable", m_valid && m_data == 8'h11, {55'b0, m_valid, m_data}, {55'b0, 1'b1, 8'h11});
    @(posedge clk); #1 m_ready = 1'b1;
    chk_bytes("R9 release", base, 4, 56'h44332211);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule